// File: doc/BRIEF.md
# Byte-Bus 16-Bit Timer and Event Counter

This block is a 16-bit up-counter that sits on an 8-bit register bus. Software sees three registers: a low byte, a high byte and a control byte. The counter can count edges on an external input pin. It can count every cycle of the internal clock. It can also measure how long the pin stays at a chosen level. When the count passes 0xFFFF, it reloads from a 16-bit preload register and raises a sticky interrupt request flag.

The bus is only one byte wide, so the 16-bit values pass through a one-byte staging buffer that reads and writes share. On a write, software first places the low byte in the buffer. A write of the high byte then commits all 16 bits at once. On a read, software first reads the high byte. That read captures the matching low byte of the count in the buffer, and a later low-byte read returns the captured value. Because of this, a running count never returns a torn 16-bit value.

The external pin passes through a two-stage synchronizer before any edge or level is examined. In pulse-width mode the block turns its own enable off when the measured level ends. The measured width then stays in the counter until software reads it.

Top module: `evt_timer16`

## Requirements
- R1: A write to address 0 (low byte) stores the data in the staging buffer only. It changes neither the preload register nor the count.
- R2: A write to address 1 (high byte) sets the preload register to {written byte, staging buffer} on that clock edge. If the run bit is 0 at that moment, the count is loaded with the same value.
- R3: A high-byte write while the run bit is 1 leaves the count on its normal path. An overflow reloads from the preload value held before that edge, so a new preload takes effect at the next overflow.
- R4: A read of address 1 returns the count's high byte and, on the same edge, copies the count's low byte into the staging buffer. A read of address 0 returns the buffer, not the live count.
- R5: Control register at address 2: bits 7:6 are the mode, bit 4 is the run bit, bit 3 is the polarity bit. Bits 5 and 2:0 read as 0. A read of address 3, or any cycle without a read, returns 0.
- R6: With the run bit 0, or with mode 00, the count holds its value.
- R7: In mode 10 (timer), the count rises by one on every clock while the run bit is 1.
- R8: In mode 01 (event), each qualifying edge of the synchronized pin adds exactly one. The edge is rising when polarity is 0 and falling when polarity is 1.
- R9: In mode 11 (pulse width), the count rises by one on each clock while the synchronized pin is at the measured level. That level is high when polarity is 0 and low when polarity is 1.
- R10: In mode 11, when the synchronized pin leaves the measured level, the hardware clears the run bit and the count stops with the width in it.
- R11: An increment at 0xFFFF loads the preload value instead, and the interrupt flag is set on the same edge.
- R12: The interrupt flag stays set until flag_clr is high on a clock edge. An overflow on the same edge as flag_clr leaves the flag set.
- R13: Synchronous reset clears the count, preload, buffer, control register and flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the internal count source in timer and pulse-width modes |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| ext_pin | input | 1 | Asynchronous external event or pulse input |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky overflow interrupt request |

## Verification
Timer mode is run from 0xFFF0 for a known number of cycles, which shows whether the count advances on every clock. A second run crosses 0xFFFF after a preload change made while the counter is running, which shows whether the reload uses the new preload value or the count register. Event mode is driven with full pulses on both polarities. The falling-edge run ends with the pin held high, so a design that counts rising edges gives a different total. Pulse-width mode is measured at both levels. Further pin activity after the stop shows whether the hardware really cleared the run bit. A high-byte read during a running count is followed by a low-byte read, which shows whether the low byte comes from the snapshot or from the live count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } tmr_sel_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      run;
        logic      fall;
    } tmr_ctrl_t;

    typedef struct packed {
        logic lo_wr;
        logic hi_wr;
        logic ctrl_wr;
        logic hi_rd;
    } tmr_strobe_t;

    localparam int unsigned CTRL_W = 8;

    function automatic logic [CTRL_W-1:0] ctrl_pack(tmr_ctrl_t c);
        return {c.mode, 1'b0, c.run, c.fall, 3'b000};
    endfunction

    function automatic tmr_ctrl_t ctrl_unpack(logic [CTRL_W-1:0] d);
        tmr_ctrl_t c;
        c.mode = tmr_mode_e'(d[7:6]);
        c.run  = d[4];
        c.fall = d[3];
        return c;
    endfunction

    function automatic tmr_strobe_t decode(logic [1:0] addr, logic wr, logic rd);
        tmr_strobe_t s;
        s.lo_wr   = wr && (addr == SEL_LO);
        s.hi_wr   = wr && (addr == SEL_HI);
        s.ctrl_wr = wr && (addr == SEL_CTRL);
        s.hi_rd   = rd && (addr == SEL_HI);
        return s;
    endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[LAST];
    end

    assign lvl  = chain_q[LAST];
    assign rise = chain_q[LAST] & ~prev_q;
    assign fall = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
    import tmr_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              hw_stop,
    output tmr_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  preload,
    output logic [CNT_W-1:0]  commit_val,
    output logic              load_now
);
    tmr_strobe_t       stb;
    logic [BYTE_W-1:0] stage_q;
    logic [CNT_W-1:0]  preload_q;
    tmr_ctrl_t         ctrl_q;
    logic [BYTE_W-1:0] rd_mux;
    logic [CTRL_W-1:0] ctrl_img;

    assign stb        = decode(bus_addr, bus_wr, bus_rd);
    assign commit_val = {bus_wdata, stage_q};
    assign load_now   = stb.hi_wr && !ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (stb.lo_wr) begin
            stage_q <= bus_wdata;
        end else if (stb.hi_rd) begin
            stage_q <= count[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            preload_q <= '0;
        end else if (stb.hi_wr) begin
            preload_q <= commit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (stb.ctrl_wr) begin
            ctrl_q <= ctrl_unpack(bus_wdata[CTRL_W-1:0]);
        end else if (hw_stop) begin
            ctrl_q.run <= 1'b0;
        end
    end

    assign ctrl_img = ctrl_pack(ctrl_q);

    always_comb begin
        rd_mux = '0;
        unique case (tmr_sel_e'(bus_addr))
            SEL_LO:   rd_mux = stage_q;
            SEL_HI:   rd_mux = count[CNT_W-1:BYTE_W];
            SEL_CTRL: rd_mux = BYTE_W'(ctrl_img);
            default:  rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
    assign ctrl      = ctrl_q;
    assign preload   = preload_q;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctrl_t        ctrl,
    input  logic             lvl,
    input  logic             rise,
    input  logic             fall,
    input  logic             load_now,
    input  logic [CNT_W-1:0] commit_val,
    input  logic [CNT_W-1:0] preload,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             hw_stop
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic             at_level;
    logic             good_edge;
    logic             end_edge;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] count_q;
    logic             flag_q;

    assign at_level  = ctrl.fall ? ~lvl : lvl;
    assign good_edge = ctrl.fall ? fall : rise;
    assign end_edge  = ctrl.fall ? rise : fall;

    always_comb begin
        tick = 1'b0;
        unique case (ctrl.mode)
            MODE_EVENT: tick = ctrl.run && good_edge;
            MODE_TIMER: tick = ctrl.run;
            MODE_PULSE: tick = ctrl.run && at_level;
            default:    tick = 1'b0;
        endcase
    end

    assign hw_stop = ctrl.run && (ctrl.mode == MODE_PULSE) && end_edge;
    assign wrap    = tick && (count_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_now) begin
            count_q <= commit_val;
        end else if (wrap) begin
            count_q <= preload;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign count = count_q;
    assign flag  = flag_q;

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import tmr_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_pin,
    input  logic              flag_clr,
    output logic              irq_flag
);
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] preload_q;
    logic [CNT_W-1:0] commit_val;
    logic [CNT_W-1:0] count_q;
    logic             load_now;
    logic             hw_stop;
    logic             pin_lvl;
    logic             pin_rise;
    logic             pin_fall;

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_async(ext_pin),
        .lvl      (pin_lvl),
        .rise     (pin_rise),
        .fall     (pin_fall)
    );

    tmr_bus_if #(.BYTE_W(BYTE_W)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count_q),
        .hw_stop   (hw_stop),
        .ctrl      (ctrl_q),
        .preload   (preload_q),
        .commit_val(commit_val),
        .load_now  (load_now)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .lvl       (pin_lvl),
        .rise      (pin_rise),
        .fall      (pin_fall),
        .load_now  (load_now),
        .commit_val(commit_val),
        .preload   (preload_q),
        .flag_clr  (flag_clr),
        .count     (count_q),
        .flag      (irq_flag),
        .hw_stop   (hw_stop)
    );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned CNT_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              flag_clr,
    input logic              irq_flag,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  preload,
    input logic [1:0]        ctrl_mode,
    input logic              ctrl_run
);
    assert_lo_write_keeps_preload_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> $stable(preload));

    assert_hi_write_commits_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1) |=> (preload[CNT_W-1:BYTE_W] == $past(bus_wdata)));

    assert_ctrl_unused_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd2) |-> (bus_rdata[5] == 1'b0 && bus_rdata[2:0] == 3'b000));

    assert_idle_holds_count_R6: assert property (@(posedge clk) disable iff (rst)
        ((!ctrl_run || ctrl_mode == 2'b00) && !(bus_wr && bus_addr == 2'd1)) |=> $stable(count));

    assert_flag_from_top_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> ($past(count) == {CNT_W{1'b1}}));

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !flag_clr) |=> irq_flag);

    assert_reset_clears_R13: assert property (@(posedge clk)
        $fell(rst) |-> (count == '0 && preload == '0 && !irq_flag && !ctrl_run));

endmodule

bind evt_timer16 tmr_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .flag_clr (flag_clr),
    .irq_flag (irq_flag),
    .count    (count_q),
    .preload  (preload_q),
    .ctrl_mode(ctrl_q.mode),
    .ctrl_run (ctrl_q.run)
);

// File: tb/tb_evt_timer16.sv
module tb_evt_timer16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_pin = 1'b0;
    logic       flag_clr = 1'b0;
    logic       irq_flag;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    sb_item_t cur;
    logic     probe_en = 1'b0;
    logic     probe_flag = 1'b0;
    int       checks = 0;
    int       errors = 0;
    logic [7:0] act;

    evt_timer16 dut (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ext_pin  (ext_pin),
        .flag_clr (flag_clr),
        .irq_flag (irq_flag)
    );

    always #4 clk = ~clk;

    // Monitor: pops expected items and compares in the middle of the cycle
    always @(negedge clk) begin
        if (probe_en) begin
            act = probe_flag ? {7'd0, irq_flag} : bus_rdata;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %h expected none", act);
            end else begin
                cur = sb_q.pop_front();
                if (act !== cur.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        step(1);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] e, string tag);
        sb_item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        bus_addr   = a;
        bus_rd     = 1'b1;
        probe_flag = 1'b0;
        probe_en   = 1'b1;
        step(1);
        bus_rd   = 1'b0;
        probe_en = 1'b0;
    endtask

    task automatic chk_flag(logic e, string tag);
        sb_item_t it;
        it.exp = {7'd0, e};
        it.tag = tag;
        sb_q.push_back(it);
        probe_flag = 1'b1;
        probe_en   = 1'b1;
        step(1);
        probe_en   = 1'b0;
        probe_flag = 1'b0;
    endtask

    task automatic rd16(logic [15:0] e, string tag);
        rd(2'd1, e[15:8], {tag, " high"});
        rd(2'd0, e[7:0], {tag, " low"});
    endtask

    task automatic load16(logic [15:0] v);
        wr(2'd2, 8'h00);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic pin_pulse(int hi_cyc, int lo_cyc);
        ext_pin = 1'b1;
        step(hi_cyc);
        ext_pin = 1'b0;
        step(lo_cyc);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);

        // R13: reset state
        rd(2'd2, 8'h00, "R13 control after reset");
        rd16(16'h0000, "R13 count after reset");
        chk_flag(1'b0, "R13 flag after reset");
        rd(2'd3, 8'h00, "R5 unmapped address");

        // R1: low write only fills the buffer; the high read then overwrites it
        wr(2'd0, 8'h34);
        rd16(16'h0000, "R1 count unchanged by low write");
        wr(2'd1, 8'h12);
        rd16(16'h1200, "R2 commit uses snapshot buffer");

        // R2: low then high commits 16 bits while disabled
        wr(2'd0, 8'h34);
        wr(2'd1, 8'h12);
        rd16(16'h1234, "R2 committed value");

        // R5 / R6: control readback and mode 00 holds the count
        wr(2'd2, 8'h2F);
        rd(2'd2, 8'h08, "R5 readback masks unused bits");
        wr(2'd2, 8'h37);
        rd(2'd2, 8'h10, "R5 run bit readback");
        step(5);
        rd16(16'h1234, "R6 mode 00 holds");

        // R7: timer mode, 6 increments
        load16(16'hFFF0);
        wr(2'd2, 8'h90);
        step(5);
        wr(2'd2, 8'h00);
        rd16(16'hFFF6, "R7 timer increments");
        chk_flag(1'b0, "R11 no flag before overflow");

        // R4: snapshot read while running
        load16(16'h00FC);
        wr(2'd2, 8'h90);
        rd(2'd1, 8'h00, "R4 high byte while running");
        rd(2'd0, 8'hFC, "R4 low byte from snapshot");
        wr(2'd2, 8'h00);
        rd16(16'h00FF, "R4 final count");

        // R3 / R11 / R12: overflow with preload changed while running, clear held
        load16(16'hFFFD);
        wr(2'd0, 8'h00);
        rd(2'd2, 8'h00, "R3 still disabled");
        load16(16'hFFFD);
        wr(2'd0, 8'h00);
        flag_clr = 1'b1;
        wr(2'd2, 8'h90);
        wr(2'd1, 8'h01);
        step(2);
        flag_clr = 1'b0;
        step(1);
        wr(2'd2, 8'h00);
        chk_flag(1'b1, "R12 set wins over clear");
        rd16(16'h0102, "R3 R11 reload uses new preload");
        step(4);
        chk_flag(1'b1, "R12 flag sticky");
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk_flag(1'b0, "R12 flag cleared");

        // R8: event rising
        load16(16'h0000);
        wr(2'd2, 8'h50);
        for (int i = 0; i < 3; i++) pin_pulse(3, 3);
        step(4);
        wr(2'd2, 8'h00);
        rd16(16'h0003, "R8 rising edges");

        // R8: event falling, ending with pin high
        load16(16'h0000);
        wr(2'd2, 8'h58);
        for (int i = 0; i < 2; i++) pin_pulse(2, 4);
        ext_pin = 1'b1;
        step(5);
        wr(2'd2, 8'h00);
        rd16(16'h0002, "R8 falling edges");
        ext_pin = 1'b0;
        step(4);
        rd16(16'h0002, "R6 disabled ignores edge");

        // R9 / R10: pulse width high level
        load16(16'h0000);
        wr(2'd2, 8'hD0);
        step(3);
        pin_pulse(7, 5);
        rd(2'd2, 8'hC0, "R10 run cleared after high pulse");
        rd16(16'h0007, "R9 high width");
        pin_pulse(4, 4);
        rd16(16'h0007, "R10 no count after stop");

        // R9 / R10: pulse width low level
        ext_pin = 1'b1;
        step(4);
        load16(16'h0000);
        wr(2'd2, 8'hD8);
        step(2);
        ext_pin = 1'b0;
        step(5);
        ext_pin = 1'b1;
        step(5);
        rd(2'd2, 8'hC8, "R10 run cleared after low pulse");
        rd16(16'h0005, "R9 low width");

        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule